// File: doc/BRIEF.md
# Sticky Alarm Interrupt Controller

The block gathers eight alarm lines into sticky status flags: two for loss of lock, two for holdover and four for loss of input signal. Each alarm line passes through a two-flop synchronizer and then sets its flag. The flag stays set after the alarm goes away and clears only when software writes a 1 to its bit.

A clear written while the synchronized alarm is still high is ignored. Each flag has its own enable bit, and all enables reset to 0. When any flag whose enable is set is itself set, a registered device interrupt bit goes high and the active-low interrupt pin goes low. A small word-wide register port gives access to the flags, the enables and the device interrupt bit.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every flag reads 0, every enable reads 0, `irq_status_o` is 0 and `int_no` is 1.
- R2: An alarm held high appears in the status register on the third rising clock edge after it is applied, and not on the second. The status register is at address 0, with loss-of-lock in bits 1:0, holdover in bits 3:2 and loss-of-signal in bits 7:4.
- R3: A flag stays set after its alarm returns low, as long as no clear is written to it.
- R4: Writing a 1 to a status bit clears that flag on the write edge when its synchronized alarm is low. Bits written with 0 keep their value.
- R5: A write-1 clear is ignored for a flag whose synchronized alarm is high on the write edge. When a set and a clear fall on the same edge, the set wins.
- R6: Writing 0 to the whole status register has no effect on any flag.
- R7: The enable register is at address 1 and can be read and written. Bit n of the enable register gates status bit n.
- R8: `irq_status_o` equals the OR over all flags of (flag AND enable), delayed by one cycle through a register. `int_no` is always its complement.
- R9: A flag whose enable is 0 never causes `irq_status_o` to go high.
- R10: Reading address 2 returns the device interrupt bit in bit 0 and zeros elsewhere. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lol_i | input | 2 | Loss-of-lock alarms, asynchronous |
| hold_i | input | 2 | Holdover alarms, asynchronous |
| los_i | input | 4 | Loss-of-signal alarms, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the addressed register |
| irq_status_o | output | 1 | Device interrupt status, active high |
| int_no | output | 1 | Interrupt pin, active low |

## Verification
The assertions assume that the register strobe and the alarm lines are sampled cleanly on the clock edge. They also assume that each write lasts exactly one cycle. The bench drives every input on the falling edge and holds each write strobe for a single cycle. The bench treats the alarms as asynchronous only in the sense that their effect appears after the two synchronizer stages. Expected values are derived from the flag pattern and the enable word applied at the inputs, never from internal state.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned N_LOL  = 2;
  localparam int unsigned N_HOLD = 2;
  localparam int unsigned N_LOS  = 4;
  localparam int unsigned N_FLAG = N_LOL + N_HOLD + N_LOS;
  localparam int unsigned AW     = 2;

  typedef enum logic [AW-1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_IRQ    = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set has priority over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flag_i & en_i);
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LOL-1:0]  lol_i,
  input  logic [N_HOLD-1:0] hold_i,
  input  logic [N_LOS-1:0]  los_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [N_FLAG-1:0] reg_wdata_i,
  output logic [N_FLAG-1:0] reg_rdata_o,
  output logic              irq_status_o,
  output logic              int_no
);
  logic [N_FLAG-1:0] alarm_raw, alarm_s, flag_q, en_q, clr_req;
  logic              wr_status, wr_enable;

  assign alarm_raw = {los_i, hold_i, lol_i};

  alarm_sync #(.WIDTH(N_FLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (alarm_raw),
    .sync_o  (alarm_s)
  );

  assign wr_status = reg_we_i && (reg_addr_i == REG_STATUS);
  assign wr_enable = reg_we_i && (reg_addr_i == REG_ENABLE);
  // a clear only lands once the alarm itself has dropped
  assign clr_req   = wr_status ? (reg_wdata_i & ~alarm_s) : '0;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (alarm_s[i]),
      .clr_i  (clr_req[i]),
      .flag_o (flag_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_enable) en_q <= reg_wdata_i;
  end

  irq_gen #(.WIDTH(N_FLAG)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_q),
    .en_i   (en_q),
    .irq_o  (irq_status_o)
  );

  assign int_no = ~irq_status_o;

  always_comb begin
    unique case (reg_addr_i)
      REG_STATUS: reg_rdata_o = flag_q;
      REG_ENABLE: reg_rdata_o = en_q;
      REG_IRQ:    reg_rdata_o = {{(N_FLAG-1){1'b0}}, irq_status_o};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
  import alarm_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [N_FLAG-1:0] alarm_s,
  input logic [N_FLAG-1:0] flag_q,
  input logic [N_FLAG-1:0] en_q,
  input logic              irq_status_o,
  input logic              int_no
);
  logic wr_st;
  assign wr_st = reg_we_i && (reg_addr_i == REG_STATUS);

  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(alarm_s)) == $past(alarm_s)));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_st |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_clear_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st |=> ((flag_q & $past(alarm_s & flag_q)) == $past(alarm_s & flag_q)));

  assert_irq_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_status_o == $past(|(flag_q & en_q))));

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_status_o);

  assert_pin_polarity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_no == !irq_status_o);
endmodule

bind alarm_irq_ctrl alarm_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .alarm_s      (alarm_s),
  .flag_q       (flag_q),
  .en_q         (en_q),
  .irq_status_o (irq_status_o),
  .int_no       (int_no)
);

// File: tb/test_alarm_irq_ctrl.sv
module test_alarm_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lol = '0, hold = '0;
  logic [3:0] los = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, int_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  alarm_irq_ctrl i_alarm_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lol_i(lol), .hold_i(hold), .los_i(los),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_status_o(irq), .int_no(int_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_alarm(input logic [7:0] v);
    {los, hold, lol} = v;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    cyc(1);
    we = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(2);
    rd(2'd0, d); chk("R1 status in reset", d, 8'h00);
    rd(2'd1, d); chk("R1 enable in reset", d, 8'h00);
    chk("R1 irq/int_n in reset", {6'd0, irq, int_n}, 8'h01);
    rst_n = 1'b1;
    cyc(1);
    rd(2'd0, d); chk("R1 status after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 enable after reset", d, 8'h00);
    rd(2'd3, d); chk("R10 unused address", d, 8'h00);

    // per-bit latency, blocked clear, sticky clear, irq latency
    wr(2'd1, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      set_alarm(8'h1 << i);
      cyc(2);
      rd(2'd0, d); chk("R2 not yet on second edge", d, 8'h00);
      cyc(1);
      rd(2'd0, d); chk("R2 set on third edge", d, 8'h1 << i);
      wr(2'd0, 8'hFF);
      rd(2'd0, d); chk("R5 clear ignored while alarm high", d, 8'h1 << i);
      set_alarm(8'h00);
      cyc(2);
      rd(2'd0, d); chk("R3 flag held after alarm drop", d, 8'h1 << i);
      chk("R8 irq high", {7'd0, irq}, 8'h01);
      wr(2'd0, 8'h1 << i);
      rd(2'd0, d); chk("R4 cleared on write edge", d, 8'h00);
      chk("R8 irq one cycle late", {7'd0, irq}, 8'h01);
      cyc(1);
      chk("R8 irq drops", {6'd0, irq, int_n}, 8'h01);
    end

    // sweep every flag pattern against several enable words
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pat, en, m;
      pat = p[7:0];
      set_alarm(pat);
      cyc(3);
      set_alarm(8'h00);
      cyc(2);
      rd(2'd0, d); chk("R2/R3 pattern stored", d, pat);
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: en = 8'h00;
          1: en = pat;
          2: en = ~pat;
          default: en = 8'hFF;
        endcase
        wr(2'd1, en);
        rd(2'd1, d); chk("R7 enable readback", d, en);
        cyc(1);
        chk("R8/R9 irq vs enable", {6'd0, irq, int_n}, {6'd0, |(pat & en), ~|(pat & en)});
        rd(2'd2, d); chk("R10 irq register", d, {7'd0, |(pat & en)});
      end
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R6 zero write", d, pat);
      m = 8'h55 ^ pat[7:0] << 1;
      wr(2'd0, m);
      rd(2'd0, d); chk("R4 partial clear", d, pat & ~m);
      wr(2'd0, 8'hFF);
      rd(2'd0, d); chk("R4 full clear", d, 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule